// File: doc/BRIEF.md
# Burst Serial Shifter

The block is a right-shifting register of configurable width that turns one start request into a self-timed burst of shifts. While it waits, it holds its contents and keeps the serial output low. When the start input is seen high in the waiting state, the controller enters its running state. It then performs exactly one shift per clock edge, a total of `WIDTH` shifts, and returns to waiting by itself. Each shift moves the least significant bit out on the serial output and takes the serial input into the most significant bit.

An asserted reset acts at once, without waiting for a clock edge. It loads the register from the parallel word, forces the controller to the waiting state with its count at zero, and clears the serial output. A typical use is to load a word through reset, pulse start, and collect `WIDTH` bits on the serial output, least significant bit first. The bits fed in on the serial input during the burst make up the word that the next burst sends out.

Top module: `burst_shifter`

## Requirements
- R1: The register width is the parameter `WIDTH`, whose default is 4. The parallel word port is `WIDTH` bits wide.
- R2: While `rst` is high, the register holds `par_word` without waiting for a clock edge, `busy` is 0 and `ser_out` is 0.
- R3: When `start` is 1 at a clock edge in the waiting state, `busy` becomes 1 after that edge. No shift occurs on that edge.
- R4: At each clock edge in the running state, `ser_out` takes the register's bit 0, the register shifts right by one, and `ser_in` enters bit `WIDTH-1`.
- R5: A burst performs exactly `WIDTH` shifts on consecutive edges. `busy` is 1 for exactly `WIDTH` cycles, and the edge that makes the last shift also returns the controller to waiting.
- R6: In the waiting state the register keeps its contents, and `ser_out` is 0 from the first edge spent waiting.
- R7: `start` has no effect while a burst runs. The burst length and the data shifted out are unchanged by it.
- R8: If `start` stays high, a new burst begins at the first edge spent waiting. `busy` is then low for exactly one cycle between bursts.
- R9: After a burst, the register holds the `WIDTH` bits taken from `ser_in` during that burst, with the first bit taken at bit 0. The next burst sends them out in that order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Active-high asynchronous reset; loads `par_word` into the register |
| par_word | input | WIDTH | Word loaded while reset is asserted |
| start | input | 1 | Burst request, sampled only in the waiting state |
| ser_in | input | 1 | Serial data into the most significant bit |
| ser_out | output | 1 | Registered serial data from bit 0 |
| busy | output | 1 | High during the running state |

## Verification
A wrong count or state shows first on `busy`. The flag is high for the wrong number of cycles, or falls too early or too late. The bench sees this within `WIDTH+1` cycles of a start. A corrupted register bit shows on `ser_out` at the edge where that bit reaches position 0, which is at most `WIDTH` edges into a burst. It can also show one burst later, once the data taken from `ser_in` is sent out. A burst restarted by a `start` that arrives mid-burst shows as `busy` staying high past `WIDTH` cycles.

// File: rtl/burst_pkg.sv
package burst_pkg;

  typedef enum logic {
    ST_WAIT = 1'b0,
    ST_RUN  = 1'b1
  } burst_state_t;

  function automatic int cnt_bits(input int depth);
    return (depth > 1) ? $clog2(depth) : 1;
  endfunction

endpackage

// File: rtl/burst_ctrl.sv
module burst_ctrl
  import burst_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic shift_go,
  output logic busy
);

  localparam int CW = cnt_bits(WIDTH);
  localparam logic [CW-1:0] LAST = CW'(WIDTH - 1);

  burst_state_t    state;
  logic [CW-1:0]   cnt;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      state <= ST_WAIT;
      cnt   <= '0;
    end else begin
      case (state)
        ST_WAIT: begin
          cnt <= '0;
          if (start) state <= ST_RUN;
        end
        ST_RUN: begin
          if (cnt == LAST) begin
            cnt   <= '0;
            state <= ST_WAIT;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: begin
          state <= ST_WAIT;
          cnt   <= '0;
        end
      endcase
    end
  end

  assign shift_go = (state == ST_RUN);
  assign busy     = (state == ST_RUN);

  // R6
  wait_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WAIT && !start) |=> (state == ST_WAIT && cnt == '0));

  // R3
  start_enter_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WAIT && start) |=> (state == ST_RUN && cnt == '0));

  // R5
  count_step_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_RUN && cnt != LAST) |=> (state == ST_RUN && cnt == $past(cnt) + 1'b1));

  // R5
  burst_end_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_RUN && cnt == LAST) |=> (state == ST_WAIT));

  // R5
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    cnt <= LAST);

endmodule

// File: rtl/shift_path.sv
module shift_path #(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] par_word,
  input  logic             shift_go,
  input  logic             ser_in,
  output logic             ser_out
);

  logic [WIDTH-1:0] sreg;
  logic [WIDTH-1:0] sreg_nxt;

  generate
    if (WIDTH == 1) begin : g_one
      assign sreg_nxt = ser_in;
    end else begin : g_many
      assign sreg_nxt = {ser_in, sreg[WIDTH-1:1]};
    end
  endgenerate

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      sreg    <= par_word;
      ser_out <= 1'b0;
    end else if (shift_go) begin
      sreg    <= sreg_nxt;
      ser_out <= sreg[0];
    end else begin
      ser_out <= 1'b0;
    end
  end

  // R4
  out_bit_chk: assert property (@(posedge clk) disable iff (rst)
    shift_go |=> (ser_out == $past(sreg[0])));

  // R4
  msb_in_chk: assert property (@(posedge clk) disable iff (rst)
    shift_go |=> (sreg[WIDTH-1] == $past(ser_in)));

  // R6
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    !shift_go |=> ($stable(sreg) && !ser_out));

endmodule

// File: rtl/burst_shifter.sv
module burst_shifter #(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] par_word,
  input  logic             start,
  input  logic             ser_in,
  output logic             ser_out,
  output logic             busy
);

  logic shift_go;

  burst_ctrl #(.WIDTH(WIDTH)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .shift_go (shift_go),
    .busy     (busy)
  );

  shift_path #(.WIDTH(WIDTH)) u_path (
    .clk      (clk),
    .rst      (rst),
    .par_word (par_word),
    .shift_go (shift_go),
    .ser_in   (ser_in),
    .ser_out  (ser_out)
  );

  // R2
  reset_quiet_chk: assert property (@(posedge clk) rst |-> (!busy && !ser_out));

endmodule

// File: tb/test_burst_shifter.sv
`timescale 1ns/1ps
module test_burst_shifter;

  localparam int W = 4;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] par_word = 4'b1011;
  logic         start = 1'b0;
  logic         ser_in = 1'b0;
  logic         ser_out;
  logic         busy;

  int n_tests = 0;
  int n_fail  = 0;

  burst_shifter i_burst_shifter (
    .clk(clk), .rst(rst), .par_word(par_word), .start(start),
    .ser_in(ser_in), .ser_out(ser_out), .busy(busy)
  );

  always #5 clk = ~clk;

  // reference model: queue of bits, index 0 is the LSB
  bit m_q[$];
  int m_run = 0;
  int m_left = 0;
  bit m_out = 0;

  always @(posedge clk or posedge rst) begin
    if (rst) begin
      m_q.delete();
      for (int i = 0; i < W; i++) m_q.push_back(par_word[i]);
      m_run = 0; m_left = 0; m_out = 0;
    end else if (m_run == 0) begin
      m_out = 0;
      if (start) begin m_run = 1; m_left = W; end
    end else begin
      m_out = m_q.pop_front();
      m_q.push_back(ser_in);
      m_left = m_left - 1;
      if (m_left == 0) m_run = 0;
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // compare against the model on every clock, away from the edge
  always @(negedge clk) begin
    if (!rst) begin
      check("R5 busy vs model", busy, m_run);
      check("R4 ser_out vs model", ser_out, m_out);
    end
  end

  int busy_cycles;
  bit got[W];

  task automatic tick(); @(negedge clk); endtask

  initial begin
    // R1
    check("R1 width", $bits(par_word), 4);
    #1;
    // R2
    check("R2 busy in reset", busy, 0);
    check("R2 ser_out in reset", ser_out, 0);
    repeat (2) tick();
    rst = 1'b0;
    tick();
    // R6: idle cycles without start
    repeat (3) tick();
    check("R6 idle ser_out", ser_out, 0);
    check("R6 idle busy", busy, 0);

    // R3/R4/R9: single pulse, feed 0110 serially (first bit 0)
    start = 1'b1; tick(); start = 1'b0;
    check("R3 busy after start", busy, 1);
    busy_cycles = 0;
    for (int i = 0; i < W; i++) begin
      ser_in = (4'b0110 >> i) & 1;
      tick();
      got[i] = ser_out;
      if (i < W - 1) busy_cycles++;
    end
    // R4: 1011 shifted out LSB first = 1,1,0,1
    check("R4 bit0", got[0], 1);
    check("R4 bit1", got[1], 1);
    check("R4 bit2", got[2], 0);
    check("R4 bit3", got[3], 1);
    check("R5 busy low after burst", busy, 0);
    tick();
    check("R6 ser_out cleared waiting", ser_out, 0);

    // R7: start held high through a burst, released before end; count busy
    ser_in = 1'b1;
    start = 1'b1; tick();
    busy_cycles = 0;
    for (int i = 0; i < W - 1; i++) begin
      if (busy) busy_cycles++;
      got[i] = ser_out; tick();
    end
    start = 1'b0;
    if (busy) busy_cycles++;
    got[W-1] = ser_out;
    tick();
    check("R7 burst length unchanged", busy_cycles, W);
    check("R7 busy ends", busy, 0);
    // R9: data from previous burst 0110 came out LSB first = 0,1,1,0
    // got[i] was sampled one cycle late; check final two via model compare, plus direct:
    check("R9 last bit out", ser_out, 0);

    // R8: continuous start, expect one low cycle between bursts
    start = 1'b1;
    repeat (W + 1) tick();
    check("R8 gap cycle low", busy, 0);
    tick();
    check("R8 restart", busy, 1);
    start = 1'b0;
    repeat (W + 2) tick();

    // R2: asynchronous reset mid burst
    start = 1'b1; tick(); start = 1'b0; tick();
    par_word = 4'b1000;
    #1 rst = 1'b1; #1;
    check("R2 async busy clear", busy, 0);
    check("R2 async ser_out clear", ser_out, 0);
    tick(); rst = 1'b0; tick();
    start = 1'b1; tick(); start = 1'b0; ser_in = 1'b0;
    repeat (W) tick();
    check("R2 loaded word msb out last", ser_out, 1);
    repeat (3) tick();

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #200000;
    n_tests++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule